// File: doc/BRIEF.md
# UART Receive Buffer with Line Status

This block holds received characters for a PC-style serial port and reports line status to software. Bytes come in either from a byte-wide valid/ready input fed by a serial receiver, or from software itself. In the second case, while the loopback input is high, a byte written to the data register is placed straight into the receive buffer. Software drains the buffer by reading the data register.

The buffer runs in one of two modes. Character mode holds one byte. FIFO mode holds sixteen bytes. The enable bit of the FIFO control register picks the mode at run time, and any change of that bit discards whatever is stored. The register port also reaches the line control register, the line status register, a scratch byte and the 16-bit divisor latch, which a baud generator outside this block uses.

The block exports the stored byte count, the overrun flag, the stored FIFO control byte and the divisor to neighbouring logic.

Top module: `uart_rx_buffer`

## Requirements
- R1: After reset the buffer is empty and one byte deep, the stored FIFO control byte is 0x00, the divisor is 12 (0x000C), line control and scratch are 0x00, and the overrun flag is clear.
- R2: A write to offset 2 whose bit 0 differs from the stored enable bit empties the buffer. The depth becomes 16 when the new bit 0 is 1 and 1 when it is 0.
- R3: A write to offset 2 with bit 0 clear stores 0x00 as the FIFO control byte, whatever the other bits are.
- R4: A write to offset 2 with bit 0 set stores only bits 0, 3, 6 and 7 of the written byte (mask 0xC9). If bit 1 is also set, the buffer is emptied.
- R5: With loopback high, a write to offset 0 (line control bit 7 clear) pushes the byte into the buffer. If the buffer is full, the byte is dropped and the overrun flag is set.
- R6: A read of offset 5 returns bits 5 and 6 as 1. Bit 0 is 1 exactly when the buffer holds at least one byte. Bits 2, 3, 4 and 7 are 0.
- R7: Bit 1 of an offset-5 read returns the overrun flag, and that read clears it.
- R8: While line control bit 7 is set, offsets 0 and 1 read and write the divisor low and high bytes, with no buffer access. Line control (offset 3) and scratch (offset 7) read back the last byte written.
- R9: Reads of offsets 2, 4 and 6, and of offset 1 while line control bit 7 is clear, return 0xFF.
- R10: A data read from an empty buffer returns the last byte read and leaves the count unchanged.
- R11: While loopback is high, bytes on the external input are accepted (ready high) and discarded.
- R12: With loopback low, the external input is ready exactly when the buffer is not full. Data reads return bytes in arrival order.
- R13: An external push and a data read in the same cycle both take effect: the read returns the oldest byte and the count is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | Received byte offered |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Offered byte is taken this cycle |
| loop_en | input | 1 | Loopback mode from modem control |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (ignored when reg_wr is high) |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, same cycle |
| rx_count | output | 5 | Bytes held in the buffer |
| overrun | output | 1 | Overrun flag |
| fcr_q | output | 8 | Stored FIFO control byte |
| divisor | output | 16 | Divisor latch {high, low} |

## Verification
The receive input and the software data read can land in the same cycle. When they do, a push and a pop must happen together without losing the count or reordering the bytes. The bench sets this up by pre-loading three bytes, then holding rx_valid high during a data-register read. It judges the result from the byte returned in that cycle, the unchanged count that follows, and the order of the bytes drained afterwards. The same collision is checked again with the buffer full, where the read returns the oldest byte and the offered byte is refused.

// File: rtl/uart_rx_buffer.sv
module uart_rx_buffer #(
  parameter int          DEPTH     = 16,
  parameter logic [15:0] RESET_DIV = 16'd12
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         rx_valid,
  input  logic [7:0]                   rx_data,
  output logic                         rx_ready,
  input  logic                         loop_en,
  input  logic                         reg_wr,
  input  logic                         reg_rd,
  input  logic [2:0]                   reg_addr,
  input  logic [7:0]                   reg_wdata,
  output logic [7:0]                   reg_rdata,
  output logic [$clog2(DEPTH+1)-1:0]   rx_count,
  output logic                         overrun,
  output logic [7:0]                   fcr_q,
  output logic [15:0]                  divisor
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int PW = $clog2(DEPTH);
  localparam logic [7:0] FCR_KEEP = 8'hC9;

  logic [7:0]    mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic [7:0]    last_q, lcr_q, scr_q, dll_q, dlh_q, fcr_r;
  logic          ovr_q;

  wire           dlab     = lcr_q[7];
  wire [CW-1:0]  cap      = fcr_r[0] ? CW'(DEPTH) : CW'(1);
  wire [PW-1:0]  last_idx = fcr_r[0] ? PW'(DEPTH - 1) : '0;
  wire           full     = (cnt == cap);
  wire           empty    = (cnt == '0);

  wire rd_op    = reg_rd & ~reg_wr;
  wire wr_data  = reg_wr & (reg_addr == 3'd0) & ~dlab;
  wire rd_data  = rd_op  & (reg_addr == 3'd0) & ~dlab;
  wire wr_fcr   = reg_wr & (reg_addr == 3'd2);
  wire rd_lsr   = rd_op  & (reg_addr == 3'd5);
  wire flush    = wr_fcr & ((reg_wdata[0] ^ fcr_r[0]) | (reg_wdata[0] & reg_wdata[1]));

  wire lb_push  = wr_data & loop_en;
  wire ext_push = rx_valid & ~loop_en;
  wire do_push  = (lb_push | ext_push) & ~full & ~flush;
  wire do_pop   = rd_data & ~empty;
  wire [7:0] push_byte = lb_push ? reg_wdata : rx_data;

  assign rx_ready = loop_en | ~full;
  assign rx_count = cnt;
  assign overrun  = ovr_q;
  assign fcr_q    = fcr_r;
  assign divisor  = {dlh_q, dll_q};

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= push_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp     <= '0;
      rp     <= '0;
      cnt    <= '0;
      last_q <= 8'h00;
      ovr_q  <= 1'b0;
      fcr_r  <= 8'h00;
      lcr_q  <= 8'h00;
      scr_q  <= 8'h00;
      dll_q  <= RESET_DIV[7:0];
      dlh_q  <= RESET_DIV[15:8];
    end else begin
      if (flush) begin
        wp  <= '0;
        rp  <= '0;
        cnt <= '0;
      end else begin
        if (do_push) wp <= (wp == last_idx) ? '0 : wp + 1'b1;
        if (do_pop)  rp <= (rp == last_idx) ? '0 : rp + 1'b1;
        if (do_push && !do_pop)      cnt <= cnt + 1'b1;
        else if (do_pop && !do_push) cnt <= cnt - 1'b1;
      end
      if (do_pop) last_q <= mem[rp];

      if (lb_push && full)  ovr_q <= 1'b1;
      else if (rd_lsr)      ovr_q <= 1'b0;

      if (wr_fcr) fcr_r <= reg_wdata[0] ? (reg_wdata & FCR_KEEP) : 8'h00;

      if (reg_wr) begin
        case (reg_addr)
          3'd0: if (dlab) dll_q <= reg_wdata;
          3'd1: if (dlab) dlh_q <= reg_wdata;
          3'd3: lcr_q <= reg_wdata;
          3'd7: scr_q <= reg_wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = dlab ? dll_q : (empty ? last_q : mem[rp]);
      3'd1:    reg_rdata = dlab ? dlh_q : 8'hFF;
      3'd3:    reg_rdata = lcr_q;
      3'd5:    reg_rdata = {1'b0, 2'b11, 3'b000, ovr_q, ~empty};
      3'd7:    reg_rdata = scr_q;
      default: reg_rdata = 8'hFF;
    endcase
  end
endmodule

module uart_rx_buffer_chk #(
  parameter int DEPTH = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       rx_valid,
  input logic                       rx_ready,
  input logic                       loop_en,
  input logic                       reg_wr,
  input logic                       reg_rd,
  input logic [2:0]                 reg_addr,
  input logic [7:0]                 reg_wdata,
  input logic [7:0]                 reg_rdata,
  input logic [$clog2(DEPTH+1)-1:0] rx_count,
  input logic                       overrun,
  input logic [7:0]                 fcr_q
);
  // R2
  depth_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(rx_count) <= (fcr_q[0] ? DEPTH : 1)));

  // R6
  lsr_fixed_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == 3'd5) |-> (reg_rdata[6:5] == 2'b11 && reg_rdata[0] == (rx_count != 0)));

  // R7
  overrun_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !reg_wr && reg_addr == 3'd5) |=> !overrun);

  // R5
  overrun_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(reg_wr && loop_en && reg_addr == 3'd0));

  // R11
  loop_discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_en && rx_valid && !reg_wr && !reg_rd) |=> (rx_count == $past(rx_count)));

  // R12
  ready_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!loop_en && 32'(rx_count) == (fcr_q[0] ? DEPTH : 1)) |-> !rx_ready);

  // R9
  unmapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 3'd2 || reg_addr == 3'd4 || reg_addr == 3'd6) |-> (reg_rdata == 8'hFF));
endmodule

bind uart_rx_buffer uart_rx_buffer_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_ready(rx_ready),
  .loop_en(loop_en), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_count(rx_count),
  .overrun(overrun), .fcr_q(fcr_q)
);

// File: tb/uart_rx_buffer_tb.sv
module uart_rx_buffer_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 0, rst_n = 0;
  logic       rx_valid = 0, loop_en = 0, reg_wr = 0, reg_rd = 0;
  logic [7:0] rx_data = 0, reg_wdata = 0;
  logic [2:0] reg_addr = 0;
  logic       rx_ready, overrun;
  logic [7:0] reg_rdata, fcr_q;
  logic [4:0] rx_count;
  logic [15:0] divisor;

  int checks = 0, fails = 0;
  bit done = 0;

  uart_rx_buffer u_dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_ready(rx_ready), .loop_en(loop_en), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .rx_count(rx_count), .overrun(overrun), .fcr_q(fcr_q), .divisor(divisor)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1 reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    #1 d = reg_rdata;
    @(posedge clk); #1 reg_rd = 0;
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk); rx_valid = 1; rx_data = b;
    @(posedge clk); #1 rx_valid = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 count", rx_count, 0);
    chk("R1 fcr", fcr_q, 0);
    chk("R1 divisor", divisor, 12);
    chk("R1 overrun", overrun, 0);
    rd(3, d); chk("R1 lcr", d, 0);
    rd(7, d); chk("R1 scratch", d, 0);
    rd(5, d); chk("R6 lsr empty", d, 8'h60);

    // R5 loopback push, depth 1 after reset
    loop_en = 1;
    wr(0, 8'h41); chk("R5 push", rx_count, 1);
    wr(0, 8'h42); chk("R1 depth one", rx_count, 1);
    chk("R5 overrun set", overrun, 1);
    rd(5, d); chk("R7 lsr with overrun", d, 8'h63);
    rd(5, d); chk("R7 overrun cleared", d, 8'h61);
    rd(0, d); chk("R12 data", d, 8'h41);
    chk("R12 count after read", rx_count, 0);
    rd(0, d); chk("R10 empty read", d, 8'h41);
    chk("R10 count", rx_count, 0);

    // R11 external bytes discarded in loopback
    @(negedge clk); rx_valid = 1; rx_data = 8'h99;
    #1 chk("R11 ready", rx_ready, 1);
    @(posedge clk); #1 rx_valid = 0;
    chk("R11 discarded", rx_count, 0);
    loop_en = 0;

    // R2 flip flushes, depth 16
    push(8'h55); chk("R12 single push", rx_count, 1);
    #1 chk("R12 not ready full", rx_ready, 0);
    wr(2, 8'h01); chk("R2 flush on enable", rx_count, 0);
    chk("R4 fcr", fcr_q, 8'h01);
    for (int i = 0; i < 16; i++) push(8'(i * 7 + 3));
    chk("R2 depth sixteen", rx_count, 16);
    chk("R12 ready low when full", rx_ready, 0);
    push(8'hEE); chk("R12 refused", rx_count, 16);
    loop_en = 1;
    wr(0, 8'hAB); chk("R5 overrun full fifo", overrun, 1);
    chk("R5 dropped", rx_count, 16);
    loop_en = 0;
    // R13 collision at full: read wins, push refused
    @(negedge clk); rx_valid = 1; rx_data = 8'hCC; reg_rd = 1; reg_addr = 0;
    #1 d = reg_rdata;
    @(posedge clk); #1 rx_valid = 0; reg_rd = 0;
    chk("R13 full read", d, 8'd3);
    chk("R13 full count", rx_count, 15);
    for (int i = 1; i < 16; i++) begin
      rd(0, d); chk("R12 order", d, (i * 7 + 3) & 8'hFF);
    end
    rd(5, d); chk("R7 lsr", d, 8'h62);
    rd(5, d); chk("R6 lsr", d, 8'h60);

    // R13 push and pop together
    push(8'h10); push(8'h20); push(8'h30);
    @(negedge clk); rx_valid = 1; rx_data = 8'h40; reg_rd = 1; reg_addr = 0;
    #1 d = reg_rdata;
    @(posedge clk); #1 rx_valid = 0; reg_rd = 0;
    chk("R13 read oldest", d, 8'h10);
    chk("R13 count unchanged", rx_count, 3);
    for (int i = 2; i <= 4; i++) begin
      rd(0, d); chk("R13 order", d, i * 16);
    end

    // R4 receiver reset with enable
    push(8'h01); push(8'h02);
    wr(2, 8'hCB); chk("R4 flush", rx_count, 0);
    chk("R4 mask", fcr_q, 8'hC9);
    push(8'h03);
    wr(2, 8'h05); chk("R4 no flush", rx_count, 1);
    chk("R4 mask tx bit", fcr_q, 8'h01);

    // R3 disable
    wr(2, 8'hFE); chk("R3 fcr zero", fcr_q, 0);
    chk("R2 flush on disable", rx_count, 0);
    push(8'h77); push(8'h78);
    chk("R2 depth one again", rx_count, 1);
    rd(0, d); chk("R12 single", d, 8'h77);

    // R8 divisor latch
    loop_en = 1;
    wr(3, 8'h80);
    rd(0, d); chk("R8 dll", d, 12);
    rd(1, d); chk("R8 dlh", d, 0);
    wr(0, 8'h34); wr(1, 8'h12);
    chk("R8 divisor", divisor, 16'h1234);
    chk("R8 no push", rx_count, 0);
    rd(0, d); chk("R8 dll read", d, 8'h34);
    wr(3, 8'h03); loop_en = 0;
    rd(3, d); chk("R8 lcr", d, 8'h03);
    rd(0, d); chk("R8 data after dlab", d, 8'h77);
    for (int v = 0; v < 256; v += 17) begin
      wr(7, 8'(v)); rd(7, d); chk("R8 scratch", d, v);
    end

    // R9 unmapped
    rd(1, d); chk("R9 off1", d, 8'hFF);
    rd(2, d); chk("R9 off2", d, 8'hFF);
    rd(4, d); chk("R9 off4", d, 8'hFF);
    rd(6, d); chk("R9 off6", d, 8'hFF);

    // R3/R4 sweep of every FCR value
    for (int v = 0; v < 256; v++) begin
      wr(2, 8'(v));
      chk(v[0] ? "R4 sweep" : "R3 sweep", fcr_q, v[0] ? (v & 8'hC9) : 0);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule